// File: doc/BRIEF.md
# Model-Cycle Delay Channel

This block carries messages from one timing-model stage to another, counting time in simulated cycles rather than hardware clocks. Every simulated cycle, the producer commits exactly one slot and the consumer takes exactly one slot. A slot holds either a real message or an empty marker (a bubble). Whatever the producer commits in its simulated cycle N reaches the consumer in the consumer's simulated cycle N+LATENCY. Each side moves through simulated time at its own pace and may spend any number of hardware clocks on one simulated cycle. No central cycle controller is needed.

The delay comes from the initial state of the channel. After reset the channel already holds LATENCY bubbles, so the consumer can finish its first LATENCY cycles before anything has been written. Back-pressure keeps each side inside the legal window. When the channel holds DEPTH slots, the producer sees `wr_ready` low. When the channel is empty, the consumer sees `rd_ready` low. A stage takes its input slot with `rd_en` at the start of its simulated cycle and commits its output slot with `wr_en` at the end. DEPTH must be at least LATENCY+1, and LATENCY may be zero.

Top module: `mtp_model_port`

## Requirements
- R1: After reset the channel holds exactly LATENCY bubbles. When LATENCY is at least 1, the first LATENCY reads return `rd_valid`=0 and the following read finds `rd_ready`=0 if nothing has been written.
- R2: With one write and one read per simulated cycle, a message committed in writer cycle N is presented in reader cycle N+LATENCY, with `rd_valid`=1 and its payload on `rd_data`.
- R3: `wr_ready` is 0 exactly when DEPTH slots are held. A `wr_en` while `wr_ready` is 0 changes nothing.
- R4: `rd_ready` is 0 exactly when no slot is held. An `rd_en` while `rd_ready` is 0 changes nothing, and a write in that same clock is still accepted.
- R5: Slots leave in the order they were written. A bubble, written with `wr_valid`=0, takes a slot exactly like a message and is read back with `rd_valid`=0.
- R6: `rd_data` is all zeros whenever `rd_valid` is 0, even if the bubble was written with a non-zero payload.
- R7: A read and a write that are both accepted in the same clock leave the occupancy, and therefore `wr_ready` and `rd_ready`, unchanged.
- R8: Clocks with neither `wr_en` nor `rd_en` leave every output unchanged, so any number of hardware clocks may pass inside one simulated cycle.
- R9: With LATENCY=0 the channel starts empty (`rd_ready`=0), and a message becomes readable in the clock after it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit the writer's slot for its current simulated cycle |
| wr_valid | input | 1 | 1 = the slot is a message, 0 = the slot is a bubble |
| wr_data | input | DATA_W | Message payload |
| wr_ready | output | 1 | The channel has a free slot |
| rd_en | input | 1 | Take the head slot for the reader's current simulated cycle |
| rd_ready | output | 1 | The channel holds at least one slot |
| rd_valid | output | 1 | The head slot is a message |
| rd_data | output | DATA_W | Payload of the head slot, zero for a bubble |

## Verification
The checker keeps its own occupancy count, starting at LATENCY and changed only by accepted handshakes. This count is correct only if the design is held in reset before the first clock edge, and only if DEPTH is at least LATENCY+1, because otherwise the preload cannot fit. The stimulus pulses reset before any enable and uses only legal parameter pairs: 2/4 and 0/1. Beyond that, enables are free inputs. The vectors deliberately include writes into a full channel and reads from an empty one, so the checker's stall properties are exercised by stimulus the assertions do not forbid.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  // Kind of occupancy change in one clock
  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_PUSH = 2'b01,
    XFER_POP  = 2'b10,
    XFER_BOTH = 2'b11
  } xfer_e;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/mtp_ptr_ctrl.sv
module mtp_ptr_ctrl
  import mtp_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned LATENCY = 2,
  localparam int unsigned PTR_W  = ptr_width(DEPTH),
  localparam int unsigned CNT_W  = cnt_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST_IDX  = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] WR_START  = PTR_W'(LATENCY % DEPTH);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  xfer_e            xfer;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;
  assign xfer    = xfer_e'({pop_ok, push_ok});

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    end
    unique case (xfer)
      XFER_PUSH: cnt_d = cnt_q + 1'b1;
      XFER_POP:  cnt_d = cnt_q - 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  // Reset state holds the LATENCY preloaded bubbles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= WR_START;
      rd_ptr_q <= '0;
      cnt_q    <= CNT_START;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_d;
      if (pop_ok)  rd_ptr_q <= rd_ptr_d;
      if (push_ok ^ pop_ok) cnt_q <= cnt_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;

endmodule

// File: rtl/mtp_slot_store.sv
module mtp_slot_store
  import mtp_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = ptr_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic              head_vld,
  output logic [DATA_W-1:0] head_data
);

  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = we & (wr_ptr == PTR_W'(gi));

    // Marker bits reset to bubble; payload needs no reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[gi] <= 1'b0;
      end else if (slot_we) begin
        vld_q[gi] <= wr_vld;
      end
    end

    always_ff @(posedge clk) begin
      if (slot_we) begin
        data_q[gi] <= wr_data;
      end
    end
  end

  always_comb begin
    head_vld  = 1'b0;
    head_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr == PTR_W'(i)) begin
        head_vld  = vld_q[i];
        head_data = data_q[i];
      end
    end
  end

endmodule

// File: rtl/mtp_model_port.sv
module mtp_model_port
  import mtp_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LATENCY = 2,
  parameter int unsigned DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned PTR_W = ptr_width(DEPTH);

  logic             push_ok, pop_ok, full, empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             head_vld;
  logic [DATA_W-1:0] head_data;

  mtp_ptr_ctrl #(
    .DEPTH   (DEPTH),
    .LATENCY (LATENCY)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (wr_en),
    .pop_req  (rd_en),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .full     (full),
    .empty    (empty)
  );

  mtp_slot_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (push_ok),
    .wr_ptr    (wr_ptr),
    .wr_vld    (wr_valid),
    .wr_data   (wr_data),
    .rd_ptr    (rd_ptr),
    .head_vld  (head_vld),
    .head_data (head_data)
  );

  logic unused_pop;
  assign unused_pop = pop_ok;

  assign wr_ready = ~full;
  assign rd_ready = ~empty;
  assign rd_valid = ~empty & head_vld;
  assign rd_data  = rd_valid ? head_data : '0;

endmodule

// File: rtl/mtp_model_port_chk.sv
module mtp_model_port_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LATENCY = 2,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              rd_en,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  logic [CNT_W-1:0] occ_q;
  logic             acc_wr, acc_rd;

  assign acc_wr = wr_en & wr_ready;
  assign acc_rd = rd_en & rd_ready;

  // Independent occupancy model built only from port handshakes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= CNT_W'(LATENCY);
    end else if (acc_wr & ~acc_rd) begin
      occ_q <= occ_q + 1'b1;
    end else if (acc_rd & ~acc_wr) begin
      occ_q <= occ_q - 1'b1;
    end
  end

  assert_wr_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == (occ_q != CNT_W'(DEPTH)));

  assert_rd_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready == (occ_q != '0));

  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && wr_en && !acc_rd) |=> !wr_ready);

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && rd_en && !acc_wr) |=> !rd_ready);

  assert_balanced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_rd) |=> ($stable(wr_ready) && $stable(rd_ready)));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> ($stable(rd_valid) && $stable(rd_data)
                            && $stable(wr_ready) && $stable(rd_ready)));

  assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !wr_valid && occ_q == '0) |=> (!rd_valid && rd_data == '0));

endmodule

bind mtp_model_port mtp_model_port_chk #(
  .DATA_W  (DATA_W),
  .LATENCY (LATENCY),
  .DEPTH   (DEPTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .wr_ready (wr_ready),
  .rd_en    (rd_en),
  .rd_ready (rd_ready),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/test_mtp_model_port.sv
`timescale 1ns/1ps
module test_mtp_model_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_valid = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, rd_ready, rd_valid;
  logic [7:0] rd_data;

  logic       z_wr_en = 1'b0, z_wr_valid = 1'b0, z_rd_en = 1'b0;
  logic [7:0] z_wr_data = '0;
  logic       z_wr_ready, z_rd_ready, z_rd_valid;
  logic [7:0] z_rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mtp_model_port #(.DATA_W(8), .LATENCY(2), .DEPTH(4)) i_mtp_model_port (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_en(rd_en), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  mtp_model_port #(.DATA_W(8), .LATENCY(0), .DEPTH(1)) i_mtp_model_port_lat0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(z_wr_en), .wr_valid(z_wr_valid), .wr_data(z_wr_data),
    .wr_ready(z_wr_ready),
    .rd_en(z_rd_en), .rd_ready(z_rd_ready), .rd_valid(z_rd_valid),
    .rd_data(z_rd_data)
  );

  // {wr_en, wr_valid, wr_data, rd_en, exp_rd_ready, exp_rd_valid, exp_rd_data, exp_wr_ready}
  // Expected values are the outputs before the step's own transfer.
  localparam int NVEC = 16;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'h11, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // preload bubble
    {1'b1, 1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // preload bubble
    {1'b1, 1'b0, 8'h33, 1'b1, 1'b1, 1'b1, 8'h11, 1'b1}, // cycle 0 message at cycle 2
    {1'b1, 1'b1, 8'h44, 1'b1, 1'b1, 1'b1, 8'h22, 1'b1},
    {1'b1, 1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1}, // bubble with payload 33 hidden
    {1'b1, 1'b1, 8'h66, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1},
    {1'b1, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0}, // full: write ignored
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h44, 1'b1},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h55, 1'b1},
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h66, 1'b1}, // 77 must not follow
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // empty: read ignored
    {1'b1, 1'b1, 8'h88, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}, // write taken, read blocked
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h88, 1'b1}, // idle clock
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h88, 1'b1},
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; z_wr_en = 1'b0; z_rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", "rd_ready", 32'(rd_ready), 32'd1);
    chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
    chk("R1", "wr_ready", 32'(wr_ready), 32'd1);
    chk("R9", "lat0 rd_ready", 32'(z_rd_ready), 32'd0);

    // Table walk, lockstep one transfer per model cycle
    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      if (i != 0) @(negedge clk);
      v = VEC[i];
      chk("R4", $sformatf("step%0d rd_ready", i), 32'(rd_ready), 32'(v[10]));
      chk("R5", $sformatf("step%0d rd_valid", i), 32'(rd_valid), 32'(v[9]));
      chk("R2/R6", $sformatf("step%0d rd_data", i), 32'(rd_data), 32'(v[8:1]));
      chk("R3", $sformatf("step%0d wr_ready", i), 32'(wr_ready), 32'(v[0]));
      wr_en = v[21]; wr_valid = v[20]; wr_data = v[19:12]; rd_en = v[11];
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;

    // R7: accepted read and write together keep occupancy (one slot held)
    wr_en = 1'b1; wr_valid = 1'b1; wr_data = 8'hA1;
    @(negedge clk);
    wr_data = 8'hA2; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R7", "rd_ready after both", 32'(rd_ready), 32'd1);
    chk("R7", "head after both", 32'(rd_data), 32'hA2);

    // R8: several idle clocks inside one model cycle
    repeat (3) @(negedge clk);
    chk("R8", "rd_valid idle", 32'(rd_valid), 32'd1);
    chk("R8", "rd_data idle", 32'(rd_data), 32'hA2);
    chk("R8", "wr_ready idle", 32'(wr_ready), 32'd1);

    // R1: reset mid-run restores exactly LATENCY bubbles
    do_reset();
    rd_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      chk("R1", $sformatf("bubble%0d rd_ready", k), 32'(rd_ready), 32'd1);
      chk("R1", $sformatf("bubble%0d rd_valid", k), 32'(rd_valid), 32'd0);
      @(negedge clk);
    end
    rd_en = 1'b0;
    chk("R1", "empty after preload", 32'(rd_ready), 32'd0);

    // R9: zero-latency channel
    chk("R9", "lat0 wr_ready", 32'(z_wr_ready), 32'd1);
    z_wr_en = 1'b1; z_wr_valid = 1'b1; z_wr_data = 8'h99;
    @(negedge clk);
    z_wr_en = 1'b0;
    chk("R9", "lat0 rd_valid", 32'(z_rd_valid), 32'd1);
    chk("R9", "lat0 rd_data", 32'(z_rd_data), 32'h99);
    chk("R3", "lat0 full", 32'(z_wr_ready), 32'd0);
    z_rd_en = 1'b1;
    @(negedge clk);
    z_rd_en = 1'b0;
    chk("R9", "lat0 drained", 32'(z_rd_ready), 32'd0);

    finish_run();
  end

endmodule